// File: doc/BRIEF.md
# Three-Bus Register-Transfer Datapath

This block is the execution core of a small processor, organised around three internal buses. Two source buses, A and B, carry operands taken from the general registers, the program counter, the memory data register and the instruction register. A single destination bus, C, carries the result back into storage. The ALU sits between them. It reads A and B directly and drives C in the same cycle, with no operand latches and no result latch in between.

A flat control word arrives on dedicated input ports every clock. It picks a driver for each source bus and an ALU operation, and it sets individual load enables for each destination. The decoder or microsequencer that produces the control word is outside the block. Memory is reached through a request/ready handshake, run by a three-state controller. IDLE moves to RD_WAIT when a read is started, or to WR_WAIT when a write is started and no read is. Each wait state holds the request until ready is seen and then returns to IDLE. The address always comes from the memory address register, and write data always comes from the memory data register.

Top module: `trio_bus_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, memory address register, memory data register, instruction register and all three flags to zero.
- R2: Bus A select codes are 0 none, 1 register port A, 2 program counter, 3 memory data register. Bus B select codes are 0 none, 1 register port B, 2 program counter, 3 memory data register, 4 immediate; codes 5 to 7 select nothing. A bus with no driver reads as zero.
- R3: ALU operation codes are 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 xor, 5 pass A, 6 pass B, 7 zero. The result appears on bus C combinationally in the same cycle as the operands.
- R4: When the flag enable is high, the zero flag (result is zero), the negative flag (top result bit) and the carry flag (carry out of add, no-borrow of subtract, zero otherwise) are captured at the clock edge. When the flag enable is low, the flags hold.
- R5: The register file has two asynchronous read ports and one write port fed from bus C at the clock edge. A read of a register that is being written in the same cycle returns the old value.
- R6: The program counter can drive bus B while it increments in the same cycle. A load from bus C takes priority over the increment.
- R7: Every destination load enable is independent, so one bus C value can be written into the register file, PC, MAR, MDR and IR in the same cycle.
- R8: The instruction register loads from bus C. On bus B it supplies its low IMM_W bits, zero-extended.
- R9: A read start in IDLE raises the request with write-enable low from the next cycle, addressed by the MAR. The request holds until ready. The MDR captures the read data in the ready cycle, and the controller then returns to IDLE.
- R10: A write start in IDLE raises the request with write-enable high. The MDR value is on the write data and the MAR value on the address, held until ready, after which the controller returns to IDLE.
- R11: Start commands given while a transfer is in progress are ignored. A read completion takes priority over a bus C load of the MDR in the same cycle.
- R12: The write index selects which general register is written, and each read index independently selects which register each read port shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 2 | Bus A driver select |
| b_sel | input | 3 | Bus B driver select |
| ra_idx | input | IDX_W | Register read index for bus A |
| rb_idx | input | IDX_W | Register read index for bus B |
| rc_idx | input | IDX_W | Register write index from bus C |
| alu_op | input | 3 | ALU operation |
| flag_en | input | 1 | Capture flags this cycle |
| ld_rf | input | 1 | Write bus C into the register file |
| ld_pc | input | 1 | Load program counter from bus C |
| pc_inc | input | 1 | Increment program counter |
| ld_mar | input | 1 | Load memory address register from bus C |
| ld_mdr | input | 1 | Load memory data register from bus C |
| ld_ir | input | 1 | Load instruction register from bus C |
| mem_rd_go | input | 1 | Start a memory read |
| mem_wr_go | input | 1 | Start a memory write |
| mem_ready | input | 1 | Memory completes the current transfer |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DATA_W | Address (MAR contents) |
| mem_wdata | output | DATA_W | Write data (MDR contents) |
| mem_busy | output | 1 | Controller not in IDLE |
| bus_c | output | DATA_W | Destination bus value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the datapath with a 4-bit word, four general registers and a 2-bit immediate. At that size every pair of operands can be combined under all eight ALU operations, and each result and each flag capture can be compared with arithmetic done in the bench. The narrow word also makes carry, borrow, wrap-around and sign easy to hit, and the narrow immediate shows the zero-extension on bus B. Directed sequences then cover both handshake directions with and without wait cycles, commands given while busy, multi-destination loads, and a reset taken after the registers hold non-zero values.

// File: rtl/trio_pkg.sv
package trio_pkg;

    typedef enum logic [1:0] {
        SA_NONE = 2'd0,
        SA_REG  = 2'd1,
        SA_PC   = 2'd2,
        SA_MDR  = 2'd3
    } src_a_e;

    typedef enum logic [2:0] {
        SB_NONE = 3'd0,
        SB_REG  = 3'd1,
        SB_PC   = 3'd2,
        SB_MDR  = 3'd3,
        SB_IMM  = 3'd4
    } src_b_e;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_PASSA = 3'd5,
        OP_PASSB = 3'd6,
        OP_ZERO  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        MS_IDLE    = 2'd0,
        MS_RD_WAIT = 2'd1,
        MS_WR_WAIT = 2'd2
    } mem_state_e;

endpackage

// File: rtl/trio_regfile.sv
module trio_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra_idx,
    input  logic [$clog2(NREG)-1:0] rb_idx,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       ra_data,
    output logic [DATA_W-1:0]       rb_data
);
    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    // R5: a write lands in the addressed entry at the edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/trio_alu.sv
module trio_alu
    import trio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              cout
);
    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, a} - {1'b0, b};

    always_comb begin
        cout = 1'b0;
        unique case (op)
            OP_ADD:   begin y = sum_w[DATA_W-1:0]; cout = sum_w[DATA_W]; end
            OP_SUB:   begin y = dif_w[DATA_W-1:0]; cout = ~dif_w[DATA_W]; end
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_PASSA: y = a;
            OP_PASSB: y = b;
            OP_ZERO:  y = '0;
            default:  y = '0;
        endcase
    end

    // R3: subtraction and xor are undone by their inverse
    always_comb begin
        if (op == OP_SUB) begin
            p_sub_inverse_r3: assert (DATA_W'(y + b) == a);
        end
        if (op == OP_XOR) begin
            p_xor_inverse_r3: assert ((y ^ b) == a);
        end
    end

endmodule

// File: rtl/trio_mem_ctl.sv
module trio_mem_ctl
    import trio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_go,
    input  logic wr_go,
    input  logic ready,
    output logic req,
    output logic we,
    output logic busy,
    output logic rd_done
);
    mem_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= MS_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE: begin
                if (rd_go)      state_nx = MS_RD_WAIT;
                else if (wr_go) state_nx = MS_WR_WAIT;
            end
            MS_RD_WAIT: if (ready) state_nx = MS_IDLE;
            MS_WR_WAIT: if (ready) state_nx = MS_IDLE;
            default:    state_nx = MS_IDLE;
        endcase
    end

    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        rd_done = 1'b0;
        unique case (state)
            MS_IDLE: ;
            MS_RD_WAIT: begin req = 1'b1; rd_done = ready; end
            MS_WR_WAIT: begin req = 1'b1; we = 1'b1; end
            default: ;
        endcase
    end

    assign busy = (state != MS_IDLE);

    // R9 and R10: an unanswered request holds with the same direction
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req && !ready) |=> (req && we == $past(we)));

    // R11: a completed transfer returns to idle, never chaining a new one
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !req);

endmodule

// File: rtl/trio_bus_datapath.sv
module trio_bus_datapath
    import trio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IMM_W  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        a_sel,
    input  logic [2:0]        b_sel,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    input  logic [2:0]        alu_op,
    input  logic              flag_en,
    input  logic              ld_rf,
    input  logic              ld_pc,
    input  logic              pc_inc,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              ld_ir,
    input  logic              mem_rd_go,
    input  logic              mem_wr_go,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_busy,
    output logic [DATA_W-1:0] bus_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c
);
    logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q;
    logic [DATA_W-1:0] rf_a, rf_b, bus_a, bus_b, imm_ext;
    logic              alu_cout, rd_done;

    trio_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra_idx(ra_idx), .rb_idx(rb_idx),
        .wr_idx(rc_idx), .wr_en(ld_rf), .wr_data(bus_c),
        .ra_data(rf_a), .rb_data(rf_b)
    );

    trio_alu #(.DATA_W(DATA_W)) u_alu (
        .op(alu_op_e'(alu_op)), .a(bus_a), .b(bus_b),
        .y(bus_c), .cout(alu_cout)
    );

    trio_mem_ctl u_mem (
        .clk(clk), .rst(rst),
        .rd_go(mem_rd_go), .wr_go(mem_wr_go), .ready(mem_ready),
        .req(mem_req), .we(mem_we), .busy(mem_busy), .rd_done(rd_done)
    );

    assign imm_ext = DATA_W'(ir_q[IMM_W-1:0]);

    always_comb begin
        unique case (src_a_e'(a_sel))
            SA_NONE: bus_a = '0;
            SA_REG:  bus_a = rf_a;
            SA_PC:   bus_a = pc_q;
            SA_MDR:  bus_a = mdr_q;
            default: bus_a = '0;
        endcase
    end

    always_comb begin
        unique case (src_b_e'(b_sel))
            SB_REG:  bus_b = rf_b;
            SB_PC:   bus_b = pc_q;
            SB_MDR:  bus_b = mdr_q;
            SB_IMM:  bus_b = imm_ext;
            default: bus_b = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            ir_q   <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            if (ld_pc)       pc_q <= bus_c;
            else if (pc_inc) pc_q <= pc_q + 1'b1;
            if (ld_mar)      mar_q <= bus_c;
            if (rd_done)     mdr_q <= mem_rdata;
            else if (ld_mdr) mdr_q <= bus_c;
            if (ld_ir)       ir_q <= bus_c;
            if (flag_en) begin
                flag_z <= (bus_c == '0);
                flag_n <= bus_c[DATA_W-1];
                flag_c <= alu_cout;
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;

    // R9: read data is captured in the ready cycle
    p_mdr_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> mdr_q == $past(mem_rdata));

    // R4: flags hold when not enabled
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable({flag_z, flag_n, flag_c}));

    // R6: a lone increment advances the counter by one
    p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !ld_pc) |=> pc_q == $past(pc_q) + 1'b1);

    // R7: the address register follows bus C when loaded
    p_mar_load_r7: assert property (@(posedge clk) disable iff (rst)
        ld_mar |=> mem_addr == $past(bus_c));

endmodule

// File: tb/tb_trio_bus_datapath.sv
`timescale 1ns/1ps
module tb_trio_bus_datapath;
    localparam int DW = 4;
    localparam int NR = 4;
    localparam int IW = 2;
    localparam int M  = (1 << DW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic [1:0]    a_sel;
    logic [2:0]    b_sel, alu_op;
    logic [1:0]    ra_idx, rb_idx, rc_idx;
    logic          flag_en, ld_rf, ld_pc, pc_inc, ld_mar, ld_mdr, ld_ir;
    logic          mem_rd_go, mem_wr_go, mem_ready;
    logic [DW-1:0] mem_rdata;
    logic          mem_req, mem_we, mem_busy, flag_z, flag_n, flag_c;
    logic [DW-1:0] mem_addr, mem_wdata, bus_c;

    trio_bus_datapath #(.DATA_W(DW), .NREG(NR), .IMM_W(IW)) dut (
        .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .rc_idx(rc_idx), .alu_op(alu_op),
        .flag_en(flag_en), .ld_rf(ld_rf), .ld_pc(ld_pc), .pc_inc(pc_inc),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
        .mem_rd_go(mem_rd_go), .mem_wr_go(mem_wr_go), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_busy(mem_busy),
        .bus_c(bus_c), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        a_sel = 0; b_sel = 0; alu_op = 0; ra_idx = 0; rb_idx = 0; rc_idx = 0;
        flag_en = 0; ld_rf = 0; ld_pc = 0; pc_inc = 0; ld_mar = 0;
        ld_mdr = 0; ld_ir = 0; mem_rd_go = 0; mem_wr_go = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mem_read(int v);
        clr(); mem_rd_go = 1; tick();
        clr(); #1;
        chk("R9 read request", {mem_req, mem_we}, 2);
        mem_ready = 1; mem_rdata = DW'(v); tick();
        mem_ready = 0;
    endtask

    task automatic put_reg(int i, int v);
        mem_read(v);
        clr(); a_sel = 3; alu_op = 5; ld_rf = 1; rc_idx = 2'(i); tick();
        clr();
    endtask

    function automatic int exp_y(int op, int a, int b);
        case (op)
            0: return (a + b) & M;
            1: return (a - b) & M;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a;
            6: return b;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_f(int op, int a, int b);
        int y, c;
        y = exp_y(op, a, b);
        c = (op == 0) ? int'((a + b) > M) : (op == 1) ? int'(a >= b) : 0;
        return (int'(y == 0) << 2) | (((y >> (DW - 1)) & 1) << 1) | c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        clr(); mem_ready = 0; mem_rdata = 0; rst = 1;
        repeat (3) tick();
        rst = 0; #1;
        // R1: state after reset
        chk("R1 flags", {flag_z, flag_n, flag_c}, 0);
        chk("R1 MAR", mem_addr, 0);
        chk("R1 MDR", mem_wdata, 0);
        a_sel = 2; alu_op = 5; #1 chk("R1 PC", bus_c, 0);
        clr(); b_sel = 4; alu_op = 6; #1 chk("R1 IR", bus_c, 0);
        chk("R9 idle", {mem_req, mem_busy}, 0);

        // R3 and R4: exhaustive operand and operation sweep
        for (int a = 0; a <= M; a++) begin
            put_reg(0, a);
            for (int b = 0; b <= M; b++) begin
                mem_read(b);
                for (int op = 0; op < 8; op++) begin
                    clr(); a_sel = 1; ra_idx = 0; b_sel = 3;
                    alu_op = 3'(op); flag_en = 1; #1;
                    chk($sformatf("R3 op%0d a=%0d b=%0d", op, a, b), bus_c, exp_y(op, a, b));
                    tick(); #1;
                    chk($sformatf("R4 flags op%0d a=%0d b=%0d", op, a, b),
                        {flag_z, flag_n, flag_c}, exp_f(op, a, b));
                end
            end
        end

        // R2: undriven and unused selects read as zero (MDR holds 15 here)
        clr(); a_sel = 0; b_sel = 0; alu_op = 0; #1 chk("R2 both none", bus_c, 0);
        clr(); b_sel = 7; alu_op = 6; #1 chk("R2 B code 7", bus_c, 0);
        clr(); a_sel = 3; b_sel = 5; alu_op = 0; #1 chk("R2 B code 5", bus_c, 15);

        // R4: flags hold with the enable low
        clr(); alu_op = 0; flag_en = 1; tick();
        clr(); a_sel = 3; alu_op = 5; tick(); #1;
        chk("R4 hold", {flag_z, flag_n, flag_c}, 4);

        // R5: same-cycle read sees the old value
        put_reg(1, 5);
        clr(); a_sel = 1; ra_idx = 1; b_sel = 3; alu_op = 0; ld_rf = 1; rc_idx = 1; #1;
        chk("R5 old value read", bus_c, 10);
        tick();
        clr(); a_sel = 1; ra_idx = 1; b_sel = 3; alu_op = 0; #1;
        chk("R5 new value", bus_c, 15);

        // R12: index selection on both read ports
        for (int i = 0; i < NR; i++) put_reg(i, 3 * i + 2);
        for (int i = 0; i < NR; i++) begin
            clr(); b_sel = 1; rb_idx = 2'(i); alu_op = 6; #1;
            chk($sformatf("R12 port B r%0d", i), bus_c, 3 * i + 2);
            clr(); a_sel = 1; ra_idx = 2'(NR - 1 - i); alu_op = 5; #1;
            chk($sformatf("R12 port A r%0d", NR - 1 - i), bus_c, 3 * (NR - 1 - i) + 2);
        end

        // R6: PC feeds MAR while incrementing, load beats increment
        mem_read(9);
        clr(); a_sel = 3; alu_op = 5; ld_pc = 1; tick();
        clr(); b_sel = 2; alu_op = 6; ld_mar = 1; pc_inc = 1; #1;
        chk("R6 PC on B", bus_c, 9);
        tick();
        clr(); b_sel = 2; alu_op = 6; #1;
        chk("R6 MAR from PC", mem_addr, 9);
        chk("R6 PC incremented", bus_c, 10);
        mem_read(3);
        clr(); a_sel = 3; alu_op = 5; ld_pc = 1; pc_inc = 1; tick();
        clr(); b_sel = 2; alu_op = 6; #1;
        chk("R6 load priority", bus_c, 3);

        // R7 and R8: one result into several destinations
        mem_read(6);
        clr(); a_sel = 3; alu_op = 5; ld_rf = 1; rc_idx = 2; ld_mar = 1; ld_ir = 1; ld_pc = 1;
        tick();
        clr(); #1 chk("R7 MAR", mem_addr, 6);
        b_sel = 1; rb_idx = 2; alu_op = 6; #1 chk("R7 reg2", bus_c, 6);
        b_sel = 2; #1 chk("R7 PC", bus_c, 6);
        b_sel = 4; #1 chk("R8 imm of 6", bus_c, 2);
        mem_read(13);
        clr(); a_sel = 3; alu_op = 5; ld_ir = 1; tick();
        clr(); b_sel = 4; alu_op = 6; #1 chk("R8 imm of 13", bus_c, 1);

        // R10: write with one wait cycle
        mem_read(11);
        clr(); mem_wr_go = 1; tick();
        clr(); #1;
        chk("R10 write request", {mem_req, mem_we}, 3);
        chk("R10 write data", mem_wdata, 11);
        chk("R10 write address", mem_addr, 6);
        tick(); #1;
        chk("R10 held while waiting", {mem_req, mem_we}, 3);
        mem_ready = 1; tick(); mem_ready = 0; #1;
        chk("R10 back to idle", {mem_req, mem_busy}, 0);

        // R11: commands while busy ignored, read completion beats bus C load
        clr(); mem_rd_go = 1; tick();
        clr(); mem_wr_go = 1; #1 chk("R11 busy", mem_busy, 1);
        tick();
        mem_wr_go = 1; mem_rd_go = 1; ld_mdr = 1; alu_op = 0;
        mem_ready = 1; mem_rdata = 4; tick();
        mem_ready = 0; clr(); #1;
        chk("R11 no chained transfer", {mem_req, mem_busy}, 0);
        chk("R11 read data wins", mem_wdata, 4);

        // R1: reset after non-zero contents
        clr(); alu_op = 0; flag_en = 1; tick();
        rst = 1; tick(); rst = 0; clr(); #1;
        chk("R1 flags again", {flag_z, flag_n, flag_c}, 0);
        chk("R1 MAR again", mem_addr, 0);
        chk("R1 MDR again", mem_wdata, 0);
        a_sel = 2; alu_op = 5; #1 chk("R1 PC again", bus_c, 0);
        clr(); b_sel = 4; alu_op = 6; #1 chk("R1 IR again", bus_c, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule